// File: doc/BRIEF.md
# External Edge-Sensing Interrupt Unit

This block watches up to seven active-low external interrupt pins, numbered 1 to 7. Bit position 0 of every register is reserved. Software selects a sensing mode for each pin: level, rising edge, falling edge or both edges. Edge events are held in a pending-flag register. Software acknowledges an event by writing a one to the matching flag bit. A per-pin enable gates each request, and a per-pin direction bit marks a pin as an input or an output. Each pin drives its own request line to a downstream interrupt controller. That controller handles priority and vectoring.

Every pin first passes through a two-flop synchronizer. An edge is seen when the synchronized value differs from its value one cycle earlier. Each pin has a two-state flag machine. State FLAG_IDLE moves to FLAG_HELD on a qualifying edge, named transition EDGE_SET. FLAG_HELD moves back to FLAG_IDLE on a clearing write with no edge in the same cycle, named transition ACK_CLEAR. FLAG_HELD stays put when an edge and a clear arrive together, named transition SET_WINS. A pin in level mode takes its request from the synchronized pin level. A pin in an edge mode takes its request from its flag.

The register bus uses a halfword index and two byte enables. It reads combinationally while `bus_sel_i` is high and `bus_wr_i` is low, and reads zero otherwise.

| Word | Byte lane 0 (bits 7:0) | Byte lane 1 (bits 15:8) |
|------|------------------------|-------------------------|
| 0 | sense-mode field, low byte | sense-mode field, high byte |
| 1 | enable | direction |
| 2 | pending flags (write one to clear) | synchronized pin levels (read only) |
| 3 | reads zero | reads zero |

Top module: `xpin_irq_unit`

## Requirements
- R1: After reset the mode field, the enable register, the direction register, all flags and all request lines are zero. Word 2 lane 1 then reads 8'hFE, because the synchronizers reset to the idle-high level.
- R2: Word 0 holds the 16-bit mode field. Pin n uses bits 2n+1:2n. Each byte enable updates only its own lane.
- R3: A pin in mode 2'b00 (level) with its enable set and its direction clear raises its request while its synchronized level is low. A change on the pin reaches the request after the second rising clock edge.
- R4: Mode 2'b01 (rising) sets the pin's flag on a low-to-high change. The flag is visible after the third rising clock edge. The request then follows the flag.
- R5: Mode 2'b10 (falling) sets the flag on a high-to-low change only.
- R6: Mode 2'b11 (both) sets the flag on either change.
- R7: A write of word 2 with byte enable 0 clears each flag whose data bit is one. Data bits that are zero leave their flags unchanged. Nothing else clears a flag.
- R8: When an edge and a clearing write reach the same flag in the same cycle, the flag stays set.
- R9: A clear enable bit forces the pin's request low. The flag still latches edges, and the request appears as soon as the enable is set.
- R10: A set direction bit (1 = output, 0 = input) stops the pin from setting its flag. In level mode it also keeps the pin's request low. `pin_dir_o` shows the direction bits.
- R11: Bit 0 of the enable, direction, flag and level registers, and bits 1:0 of the mode field, ignore writes and read zero.
- R12: In level mode, pin changes never set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NPINS (7) | External interrupt pins 1..NPINS, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Halfword index |
| bus_be_i | input | 2 | Byte-lane enables |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |
| pin_dir_o | output | NPINS (7) | Direction bits of pins 1..NPINS |
| irq_o | output | NPINS (7) | Request line of each pin |

## Verification
The bench aims at three timing cases. The first is a clearing write that lands in the same cycle as a new edge; a design that lets the clear win would silently lose an interrupt. The second is synchronizer latency; a design with one flop too few or too many would show level requests and flags one cycle early or late against the model. The third is the ignored stimulus: edges in level mode, edges on output-direction pins, zero bits in a clear, and writes to the reserved bit 0. A design that reacted to any of these would show stray flags in the word 2 readback, or stray request pulses, on the cycle after the stimulus.

// File: rtl/xpin_irq_pkg.sv
package xpin_irq_pkg;

    localparam int REG_W  = 8;
    localparam int MODE_W = 2 * REG_W;
    localparam int ADDR_W = 2;
    localparam int BE_W   = 2;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_RISE  = 2'b01,
        SENSE_FALL  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

    localparam logic [ADDR_W-1:0] WORD_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] WORD_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] WORD_STAT = 2'd2;

    // Writable bits of a one-bit-per-pin register: 1..npins, bit 0 reserved.
    function automatic logic [REG_W-1:0] pin_mask(int npins);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 1; i < REG_W; i++) begin
            if (i <= npins) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Writable bits of the two-bit-per-pin mode field.
    function automatic logic [MODE_W-1:0] mode_mask(int npins);
        logic [MODE_W-1:0] m;
        m = '0;
        for (int i = 1; i < REG_W; i++) begin
            if (i <= npins) m[2*i +: 2] = 2'b11;
        end
        return m;
    endfunction

endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
    parameter int   W       = 7,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= {W{RST_VAL}};
            stage2_q <= {W{RST_VAL}};
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/xpin_regfile.sv
module xpin_regfile
    import xpin_irq_pkg::*;
#(
    parameter int NPINS = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [REG_W-1:0]  flags_i,
    input  logic [REG_W-1:0]  levels_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [REG_W-1:0]  en_o,
    output logic [REG_W-1:0]  dir_o,
    output logic [REG_W-1:0]  clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [REG_W-1:0]  PMASK = pin_mask(NPINS);
    localparam logic [MODE_W-1:0] MMASK = mode_mask(NPINS);

    logic wr_hit;
    logic rd_hit;

    assign wr_hit = sel_i & wr_i;
    assign rd_hit = sel_i & ~wr_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_o <= '0;
            en_o   <= '0;
            dir_o  <= '0;
        end else if (wr_hit) begin
            if (addr_i == WORD_MODE) begin
                if (be_i[0]) mode_o[7:0]  <= wdata_i[7:0]  & MMASK[7:0];
                if (be_i[1]) mode_o[15:8] <= wdata_i[15:8] & MMASK[15:8];
            end
            if (addr_i == WORD_CTRL) begin
                if (be_i[0]) en_o  <= wdata_i[7:0]  & PMASK;
                if (be_i[1]) dir_o <= wdata_i[15:8] & PMASK;
            end
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_hit && (addr_i == WORD_STAT) && be_i[0]) begin
            clr_o = wdata_i[7:0] & PMASK;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_hit) begin
            unique case (addr_i)
                WORD_MODE: rdata_o = mode_o;
                WORD_CTRL: rdata_o = {dir_o, en_o};
                WORD_STAT: rdata_o = {levels_i & PMASK, flags_i & PMASK};
                default:   rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/xpin_pin_cell.sv
module xpin_pin_cell
    import xpin_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sync_i,
    input  logic [1:0] mode_i,
    input  logic       en_i,
    input  logic       dir_i,
    input  logic       clr_i,
    output logic       flag_o,
    output logic       irq_o
);

    sense_e      mode;
    flag_state_e state_q;
    flag_state_e state_d;
    logic        prev_q;
    logic        rise;
    logic        fall;
    logic        edge_hit;

    assign mode = sense_e'(mode_i);
    assign rise = sync_i & ~prev_q;
    assign fall = ~sync_i & prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b1;
        else         prev_q <= sync_i;
    end

    always_comb begin
        unique case (mode)
            SENSE_LEVEL: edge_hit = 1'b0;
            SENSE_RISE:  edge_hit = rise;
            SENSE_FALL:  edge_hit = fall;
            SENSE_BOTH:  edge_hit = rise | fall;
            default:     edge_hit = 1'b0;
        endcase
        if (dir_i) edge_hit = 1'b0;
    end

    // Flag state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= FLAG_IDLE;
        else         state_q <= state_d;
    end

    // Next state: EDGE_SET, ACK_CLEAR, SET_WINS
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (edge_hit) state_d = FLAG_HELD;
            FLAG_HELD: if (clr_i && !edge_hit) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        flag_o = (state_q == FLAG_HELD);
        if (mode == SENSE_LEVEL) irq_o = en_i & ~dir_i & ~sync_i;
        else                     irq_o = en_i & flag_o;
    end

endmodule

// File: rtl/xpin_irq_unit.sv
module xpin_irq_unit
    import xpin_irq_pkg::*;
#(
    parameter int NPINS = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPINS:1]    pins_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BE_W-1:0]   bus_be_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NPINS:1]    pin_dir_o,
    output logic [NPINS:1]    irq_o
);

    logic [NPINS:1]    pin_sync;
    logic [NPINS:1]    cell_flag;
    logic [REG_W-1:0]  level_vec;
    logic [REG_W-1:0]  flag_q;
    logic [MODE_W-1:0] mode_q;
    logic [REG_W-1:0]  en_q;
    logic [REG_W-1:0]  dir_q;
    logic [REG_W-1:0]  clr_vec;

    xpin_sync #(.W(NPINS), .RST_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pins_i),
        .q_o    (pin_sync)
    );

    always_comb begin
        level_vec           = '0;
        level_vec[NPINS:1]  = pin_sync;
        flag_q              = '0;
        flag_q[NPINS:1]     = cell_flag;
    end

    xpin_regfile #(.NPINS(NPINS)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .be_i     (bus_be_i),
        .wdata_i  (bus_wdata_i),
        .flags_i  (flag_q),
        .levels_i (level_vec),
        .mode_o   (mode_q),
        .en_o     (en_q),
        .dir_o    (dir_q),
        .clr_o    (clr_vec),
        .rdata_o  (bus_rdata_o)
    );

    for (genvar n = 1; n <= NPINS; n++) begin : g_pin
        xpin_pin_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sync_i (pin_sync[n]),
            .mode_i (mode_q[2*n +: 2]),
            .en_i   (en_q[n]),
            .dir_i  (dir_q[n]),
            .clr_i  (clr_vec[n]),
            .flag_o (cell_flag[n]),
            .irq_o  (irq_o[n])
        );
    end

    assign pin_dir_o = dir_q[NPINS:1];

endmodule

// File: rtl/xpin_irq_chk.sv
module xpin_irq_chk
    import xpin_irq_pkg::*;
#(
    parameter int NPINS = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NPINS:1]    irq_o,
    input logic [REG_W-1:0]  en_q,
    input logic [REG_W-1:0]  dir_q,
    input logic [MODE_W-1:0] mode_q,
    input logic [REG_W-1:0]  flag_q,
    input logic [REG_W-1:0]  clr_q
);

    for (genvar n = 1; n <= NPINS; n++) begin : g_chk
        // R9
        irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[n] |-> en_q[n]);

        // R10
        dir_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(dir_q[n]) |-> !$rose(flag_q[n]));

        // R12
        level_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(mode_q[2*n +: 2]) == 2'b00) |-> !$rose(flag_q[n]));

        // R7
        clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(flag_q[n]) |-> $past(clr_q[n]));
    end

endmodule

bind xpin_irq_unit xpin_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_o  (irq_o),
    .en_q   (en_q),
    .dir_q  (dir_q),
    .mode_q (mode_q),
    .flag_q (flag_q),
    .clr_q  (clr_vec)
);

// File: tb/xpin_irq_unit_bench.sv
module xpin_irq_unit_bench;

    logic        clk;
    logic        rst_n;
    logic [7:1]  pins;
    logic        sel;
    logic        wr;
    logic [1:0]  addr;
    logic [1:0]  be;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [7:1]  dir_out;
    logic [7:1]  irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    logic [15:0] m_mode;
    logic [7:0]  m_en, m_dir, m_flag, m_s1, m_s2, m_prev;

    xpin_irq_unit #(.NPINS(7)) u_xpin_irq_unit (
        .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_be_i(be),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pin_dir_o(dir_out), .irq_o(irq)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    task automatic model_reset();
        m_mode = '0; m_en = '0; m_dir = '0; m_flag = '0;
        m_s1 = 8'hFF; m_s2 = 8'hFF; m_prev = 8'hFF;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic [7:0] nflag;
            nflag = m_flag;
            for (int n = 1; n < 8; n++) begin
                bit rise, fall, hit, clr;
                logic [1:0] md;
                md   = m_mode[2*n +: 2];
                rise = m_s2[n] && !m_prev[n];
                fall = !m_s2[n] && m_prev[n];
                hit  = !m_dir[n] && ((md == 2'b01 && rise) || (md == 2'b10 && fall) ||
                                     (md == 2'b11 && (rise || fall)));
                clr  = sel && wr && addr == 2'd2 && be[0] && wdata[n];
                if (hit) nflag[n] = 1'b1;
                else if (clr) nflag[n] = 1'b0;
            end
            if (sel && wr && addr == 2'd0) begin
                if (be[0]) m_mode[7:0]  = wdata[7:0] & 8'hFC;
                if (be[1]) m_mode[15:8] = wdata[15:8];
            end
            if (sel && wr && addr == 2'd1) begin
                if (be[0]) m_en  = wdata[7:0]  & 8'hFE;
                if (be[1]) m_dir = wdata[15:8] & 8'hFE;
            end
            m_flag = nflag;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = {pins, 1'b1};
        end
    end

    function automatic logic [7:1] exp_irq();
        logic [7:1] r;
        for (int n = 1; n < 8; n++) begin
            if (m_mode[2*n +: 2] == 2'b00) r[n] = m_en[n] && !m_dir[n] && !m_s2[n];
            else                           r[n] = m_en[n] && m_flag[n];
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_rdata();
        if (!(sel && !wr)) return 16'h0;
        case (addr)
            2'd0:    return m_mode;
            2'd1:    return {m_dir, m_en};
            2'd2:    return {m_s2 & 8'hFE, m_flag};
            default: return 16'h0;
        endcase
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (irq !== exp_irq()) begin
                mismatched++;
                $display("FAIL %s irq_o actual=%h expected=%h t=%0t", cur_req, irq, exp_irq(), $time);
            end
            compared++;
            if (dir_out !== m_dir[7:1]) begin
                mismatched++;
                $display("FAIL %s pin_dir_o actual=%h expected=%h", cur_req, dir_out, m_dir[7:1]);
            end
            if (sel && !wr) begin
                compared++;
                if (rdata !== exp_rdata()) begin
                    mismatched++;
                    $display("FAIL %s rdata word%0d actual=%h expected=%h", cur_req, addr, rdata, exp_rdata());
                end
            end
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic bus_wr(logic [1:0] a, logic [1:0] b, logic [15:0] d);
        step();
        sel = 1; wr = 1; addr = a; be = b; wdata = d;
        step();
        sel = 0; wr = 0;
    endtask

    task automatic bus_rd(logic [1:0] a);
        step();
        sel = 1; wr = 0; addr = a; be = 2'b11;
        step();
        sel = 0;
    endtask

    task automatic set_pin(int n, logic v);
        step();
        pins[n] = v;
    endtask

    initial begin
        rst_n = 0; pins = '1; sel = 0; wr = 0; addr = 0; be = 0; wdata = 0;
        // R1: reset state
        cur_req = "R1";
        step(3);
        rst_n = 1;
        bus_rd(0); bus_rd(1); bus_rd(2); bus_rd(3);

        // R2: mode field layout and byte lanes
        cur_req = "R2";
        bus_wr(0, 2'b11, 16'hFFFF); bus_rd(0);
        bus_wr(0, 2'b10, 16'h1200); bus_rd(0);
        bus_wr(0, 2'b01, 16'h0055); bus_rd(0);

        // R11: reserved bit 0
        cur_req = "R11";
        bus_wr(1, 2'b11, 16'h0101); bus_rd(1);
        bus_wr(2, 2'b01, 16'h0001); bus_rd(2);

        // Modes: p1 level, p2 rise, p3 fall, p4 both, p5 rise, p6 rise, p7 level
        bus_wr(0, 2'b11, {2'b00, 2'b01, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00, 2'b00});
        bus_wr(1, 2'b11, {8'h00, 8'b1101_1110}); // p5 enable off
        bus_rd(0);

        // R3: level request
        cur_req = "R3";
        set_pin(1, 0); step(4); set_pin(1, 1); step(4);

        // R12: level mode never sets the flag
        cur_req = "R12";
        set_pin(1, 0); step(2); set_pin(1, 1); step(3); bus_rd(2);

        // R4: rising edge
        cur_req = "R4";
        set_pin(2, 0); step(4); bus_rd(2); set_pin(2, 1); step(4); bus_rd(2);

        // R5: falling edge
        cur_req = "R5";
        set_pin(3, 0); step(4); bus_rd(2); set_pin(3, 1); step(4); bus_rd(2);

        // R6: both edges
        cur_req = "R6";
        set_pin(4, 0); step(4); bus_rd(2);
        bus_wr(2, 2'b01, 16'h0010); step(2);
        set_pin(4, 1); step(4); bus_rd(2);

        // R7: write-one-to-clear, zero bits ignored
        cur_req = "R7";
        bus_wr(2, 2'b01, 16'h0000); bus_rd(2);
        bus_wr(2, 2'b10, 16'hFF00); bus_rd(2);
        bus_wr(2, 2'b01, 16'h0004); bus_rd(2);

        // R8: edge in the same cycle as a clearing write
        cur_req = "R8";
        set_pin(4, 0);
        step();
        step();
        sel = 1; wr = 1; addr = 2; be = 2'b01; wdata = 16'h0010;
        step();
        sel = 0; wr = 0;
        bus_rd(2); step(3);

        // R9: enable gates request, flag still latches
        cur_req = "R9";
        set_pin(5, 0); step(1); set_pin(5, 1); step(4); bus_rd(2);
        bus_wr(1, 2'b01, 16'h00FE); step(2);

        // R10: output direction blocks detection and level request
        cur_req = "R10";
        bus_wr(1, 2'b10, 16'hC000); bus_rd(1);
        set_pin(6, 0); step(2); set_pin(6, 1); step(4);
        set_pin(7, 0); step(4); bus_rd(2); set_pin(7, 1);
        bus_wr(1, 2'b10, 16'h0000); set_pin(7, 0); step(4); set_pin(7, 1); step(3);

        // mixed traffic across all modes
        cur_req = "R6";
        for (int c = 0; c < 3000; c++) begin
            step();
            if ($urandom_range(0, 3) == 0) pins[$urandom_range(1, 7)] ^= 1'b1;
            sel = 0; wr = 0;
            if ($urandom_range(0, 3) == 0) begin
                sel = 1; wr = $urandom_range(0, 1); addr = $urandom_range(0, 3);
                be = $urandom_range(0, 3); wdata = $urandom();
            end
        end
        sel = 0; wr = 0;
        step(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule